// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog timer that counts strobes from a slow oscillator and issues a one-cycle reset pulse when the selected time-out runs out. Software can restart the count at any time with a kick. The time-out is chosen by a 4-bit select code. Each select code picks a power-of-two number of oscillator ticks.

A write interface sets the configuration. Three fields can be written: a run (enable) bit, an arm (change-enable) bit and the select code. Some changes are guarded. A guarded change must first be armed by a write that sets arm and run together. The write that carries the new value must then follow within four clock cycles, with arm at zero. A static input picks one of two protection levels. At level 1 the timer starts stopped, the select code can be written freely, and only stopping the timer is guarded. At level 2 the timer always runs and the select code is the guarded field.

Top module: `wdt_guard`

## Requirements
- R1: After reset, rst_pulse is 0, rd_arm is 0 and rd_sel is 0. rd_run is 0 when safe_lvl2=0 and 1 when safe_lvl2=1.
- R2: At level 1, a write with wr_arm=0 stores wr_sel. If wr_run=1 it also sets run, with no arming needed.
- R3: At level 1, outside an open window, a write with wr_arm=0 and wr_run=0 leaves run at 1.
- R4: A write with wr_arm=1 and wr_run=1 opens the window, and rd_arm reads 1 from the next cycle. The select code and, at level 2, the run state are left unchanged by this write.
- R5: A write with wr_arm=0 accepted at any of the four clock edges after the arming edge applies its fields and closes the window (rd_arm=0). At level 1 it applies wr_run and wr_sel.
- R6: If no such write arrives, rd_arm drops to 0 after the fourth edge following the arming write. A guarded write after that point is ignored.
- R7: At level 2, rd_run always reads 1 and the timer counts from reset.
- R8: At level 2, a select write outside the window is ignored. Inside the window the new code is applied and the wr_run value of that write has no effect.
- R9: Code c < NUM_CODES gives a time-out of 2^(BASE_LOG+c) osc_tick strobes. Codes at or above NUM_CODES act as code NUM_CODES-1.
- R10: rst_pulse is high for exactly one cycle, and the count then restarts from zero.
- R11: kick clears the count, so a full time-out is needed again before the next pulse.
- R12: While the timer is stopped, no pulse is produced, however many ticks arrive.
- R13: A write with wr_arm=1 and wr_run=0 is ignored completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| safe_lvl2 | input | 1 | Static protection level: 0 = level 1, 1 = level 2 |
| osc_tick | input | 1 | One-cycle strobe from the slow watchdog oscillator |
| kick | input | 1 | Restarts the time-out count |
| wr_en | input | 1 | Configuration write strobe |
| wr_arm | input | 1 | Change-enable field of the write |
| wr_run | input | 1 | Enable field of the write |
| wr_sel | input | 4 | Time-out select field of the write |
| rd_arm | output | 1 | Window open (change-enable readback) |
| rd_run | output | 1 | Effective enable readback |
| rd_sel | output | 4 | Current time-out select |
| rst_pulse | output | 1 | One-cycle watchdog reset request |

## Verification
The time-out is swept over all sixteen select codes with a small base exponent. Each code is driven one tick short of the expected period and then to the full period, and then once more after the pulse. This separates an off-by-one tap from a wrong clamp of the reserved codes and from a count that fails to restart. The gap between the arming write and the second write is swept from zero to four idle cycles, which separates a window that is one cycle too short or too long from a correct one. The same guarded writes are then repeated at both protection levels, which shows which field each level protects and that malformed arming writes change nothing.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

   localparam int SEL_W = 4;

   typedef struct packed {
      logic             valid;
      logic             arm;
      logic             run;
      logic [SEL_W-1:0] sel;
   } wdt_wr_t;

   typedef enum logic [1:0] {
      WK_NONE   = 2'd0,
      WK_ARM    = 2'd1,
      WK_DATA   = 2'd2,
      WK_BOGUS  = 2'd3
   } wdt_wkind_e;

endpackage

// File: rtl/wdt_unlock_win.sv
module wdt_unlock_win #(
   parameter int WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_req,
   input  logic commit,
   output logic arm
);
   localparam int CW = $clog2(WIN + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (open_req) begin
         left_q <= CW'(WIN);
      end else if (commit) begin
         left_q <= '0;
      end else if (left_q != '0) begin
         left_q <= left_q - CW'(1);
      end
   end

   assign arm = (left_q != '0);

endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
   import wdt_guard_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl2,
   input  wdt_wr_t          req,
   input  logic             win_open,
   output logic             open_req,
   output logic             commit,
   output logic             run_eff,
   output logic [SEL_W-1:0] sel_q
);
   wdt_wkind_e       kind;
   logic             run_q;
   logic             run_d;
   logic [SEL_W-1:0] sel_d;

   always_comb begin
      if (!req.valid)                kind = WK_NONE;
      else if (req.arm && req.run)   kind = WK_ARM;
      else if (req.arm)              kind = WK_BOGUS;
      else                           kind = WK_DATA;
   end

   assign open_req = (kind == WK_ARM);
   assign commit   = (kind == WK_DATA) && win_open;

   always_comb begin
      run_d = run_q;
      sel_d = sel_q;
      if (lvl2) begin
         if (commit) sel_d = req.sel;
      end else begin
         unique case (kind)
            WK_ARM:  run_d = 1'b1;
            WK_DATA: begin
               sel_d = req.sel;
               run_d = win_open ? req.run : (run_q | req.run);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         sel_q <= '0;
      end else begin
         run_q <= run_d;
         sel_q <= sel_d;
      end
   end

   assign run_eff = lvl2 | run_q;

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int BASE_LOG  = 11,
   parameter int NUM_CODES = 10,
   parameter int SEL_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             kick,
   input  logic [SEL_W-1:0] sel,
   output logic             fire
);
   localparam int CNT_W = BASE_LOG + NUM_CODES - 1;

   logic [CNT_W-1:0]     cnt_q;
   logic [NUM_CODES-1:0] tap;
   logic [SEL_W-1:0]     code_c;
   logic                 hit;

   for (genvar i = 0; i < NUM_CODES; i++) begin : g_tap
      assign tap[i] = &cnt_q[BASE_LOG+i-1:0];
   end

   if (NUM_CODES == (1 << SEL_W)) begin : g_full
      assign code_c = sel;
   end else begin : g_clamp
      assign code_c = (sel >= SEL_W'(NUM_CODES)) ? SEL_W'(NUM_CODES - 1) : sel;
   end

   assign hit = tap[code_c];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         fire  <= 1'b0;
      end else if (!en || kick) begin
         cnt_q <= '0;
         fire  <= 1'b0;
      end else if (tick) begin
         if (hit) begin
            cnt_q <= '0;
            fire  <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            fire  <= 1'b0;
         end
      end else begin
         fire <= 1'b0;
      end
   end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int BASE_LOG   = 11,
   parameter int NUM_CODES  = 10,
   parameter int UNLOCK_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             safe_lvl2,
   input  logic             osc_tick,
   input  logic             kick,
   input  logic             wr_en,
   input  logic             wr_arm,
   input  logic             wr_run,
   input  logic [SEL_W-1:0] wr_sel,
   output logic             rd_arm,
   output logic             rd_run,
   output logic [SEL_W-1:0] rd_sel,
   output logic             rst_pulse
);
   if (BASE_LOG < 1) begin : g_bad_base
      $error("wdt_guard: BASE_LOG must be at least 1");
   end
   if (NUM_CODES < 1 || NUM_CODES > (1 << SEL_W)) begin : g_bad_codes
      $error("wdt_guard: NUM_CODES must be 1..2**SEL_W");
   end
   if (UNLOCK_CYC < 1) begin : g_bad_win
      $error("wdt_guard: UNLOCK_CYC must be at least 1");
   end

   wdt_wr_t req;
   logic    open_req;
   logic    commit;
   logic    win_open;
   logic    run_eff;

   assign req = '{valid: wr_en, arm: wr_arm, run: wr_run, sel: wr_sel};

   wdt_unlock_win #(.WIN(UNLOCK_CYC)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_req (open_req),
      .commit   (commit),
      .arm      (win_open)
   );

   wdt_cfg_reg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl2     (safe_lvl2),
      .req      (req),
      .win_open (win_open),
      .open_req (open_req),
      .commit   (commit),
      .run_eff  (run_eff),
      .sel_q    (rd_sel)
   );

   wdt_prescale #(
      .BASE_LOG  (BASE_LOG),
      .NUM_CODES (NUM_CODES),
      .SEL_W     (SEL_W)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (run_eff),
      .tick  (osc_tick),
      .kick  (kick),
      .sel   (rd_sel),
      .fire  (rst_pulse)
   );

   assign rd_arm = win_open;
   assign rd_run = run_eff;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
   parameter int UNLOCK_CYC = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       safe_lvl2,
   input logic       osc_tick,
   input logic       kick,
   input logic       wr_en,
   input logic       wr_arm,
   input logic       wr_run,
   input logic [3:0] rd_sel,
   input logic       rd_arm,
   input logic       rd_run,
   input logic       rst_pulse
);
   int open_len;

   always_ff @(posedge clk) begin
      if (!rst_n)                          open_len <= 0;
      else if (wr_en && wr_arm && wr_run)  open_len <= 0;
      else if (rd_arm)                     open_len <= open_len + 1;
      else                                 open_len <= 0;
   end

   p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   p_lvl2_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      safe_lvl2 |-> rd_run);

   p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_arm && rd_run) |=> rd_run);

   p_sel_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (safe_lvl2 && !rd_arm) |=> $stable(rd_sel));

   p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_run |=> !rst_pulse);

   p_win_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_arm |-> (open_len < UNLOCK_CYC));

   p_tick_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> $past(osc_tick && !kick && rd_run));

   p_bad_arm_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_arm && !wr_run && !rd_arm) |=> (!rd_arm && $stable(rd_sel)));

endmodule

bind wdt_guard wdt_guard_chk #(.UNLOCK_CYC(UNLOCK_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .safe_lvl2 (safe_lvl2),
   .osc_tick  (osc_tick),
   .kick      (kick),
   .wr_en     (wr_en),
   .wr_arm    (wr_arm),
   .wr_run    (wr_run),
   .rd_sel    (rd_sel),
   .rd_arm    (rd_arm),
   .rd_run    (rd_run),
   .rst_pulse (rst_pulse)
);

// File: tb/wdt_guard_tb.sv
`timescale 1ns/1ps
module wdt_guard_tb;
   localparam int BASE_LOG  = 1;
   localparam int NUM_CODES = 10;
   localparam int WIN       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       safe_lvl2 = 1'b0;
   logic       osc_tick = 1'b0;
   logic       kick = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_arm = 1'b0;
   logic       wr_run = 1'b0;
   logic [3:0] wr_sel = '0;
   logic       rd_arm;
   logic       rd_run;
   logic [3:0] rd_sel;
   logic       rst_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wdt_guard #(
      .BASE_LOG   (BASE_LOG),
      .NUM_CODES  (NUM_CODES),
      .UNLOCK_CYC (WIN)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .safe_lvl2 (safe_lvl2),
      .osc_tick  (osc_tick),
      .kick      (kick),
      .wr_en     (wr_en),
      .wr_arm    (wr_arm),
      .wr_run    (wr_run),
      .wr_sel    (wr_sel),
      .rd_arm    (rd_arm),
      .rd_run    (rd_run),
      .rd_sel    (rd_sel),
      .rst_pulse (rst_pulse)
   );

   function automatic int period(input int code);
      int c = (code >= NUM_CODES) ? NUM_CODES - 1 : code;
      return 1 << (BASE_LOG + c);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic lvl);
      rst_n = 1'b0;
      safe_lvl2 = lvl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic r, input int s);
      wr_en = 1'b1; wr_arm = a; wr_run = r; wr_sel = 4'(s);
      @(negedge clk);
      wr_en = 1'b0; wr_arm = 1'b0; wr_run = 1'b0; wr_sel = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_kick();
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   task automatic ticks(input int n, output int pulses, output int last);
      pulses = 0;
      osc_tick = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_pulse) pulses++;
      end
      osc_tick = 1'b0;
      last = int'(rst_pulse);
   endtask

   // Full time-out check for the current select code, starting from a kicked count.
   task automatic timeout_run(input int code);
      int p, l, t;
      string tag;
      t = period(code);
      tag = $sformatf("R9 code %0d", code);
      do_kick();
      ticks(t - 1, p, l);
      chk({tag, " early"}, p, 0);
      ticks(1, p, l);
      chk({tag, " expiry"}, l, 1);
      idle(1);
      chk("R10 single cycle pulse", int'(rst_pulse), 0);
      ticks(t - 1, p, l);
      chk("R10 restart from zero", p, 0);
      ticks(1, p, l);
      chk("R10 second expiry", l, 1);
      idle(1);
   endtask

   initial begin
      int p, l;

      // ---------------- level 1 ----------------
      do_reset(1'b0);
      chk("R1 run", int'(rd_run), 0);
      chk("R1 arm", int'(rd_arm), 0);
      chk("R1 sel", int'(rd_sel), 0);
      chk("R1 pulse", int'(rst_pulse), 0);

      ticks(3000, p, l);
      chk("R12 stopped timer", p, 0);

      wr(1'b0, 1'b1, 2);
      chk("R2 run set", int'(rd_run), 1);
      chk("R2 sel set", int'(rd_sel), 2);
      chk("R2 arm stays 0", int'(rd_arm), 0);

      for (int c = 0; c < 16; c++) begin
         wr(1'b0, 1'b1, c);
         chk("R2 sel sweep", int'(rd_sel), c);
         timeout_run(c);
      end

      wr(1'b0, 1'b1, 3);
      do_kick();
      ticks(period(3) - 1, p, l);
      do_kick();
      ticks(period(3) - 1, p, l);
      chk("R11 kick clears count", p, 0);
      ticks(1, p, l);
      chk("R11 expiry after kick", l, 1);
      idle(1);

      wr(1'b0, 1'b0, 3);
      chk("R3 run not cleared", int'(rd_run), 1);

      wr(1'b1, 1'b0, 5);
      chk("R13 arm", int'(rd_arm), 0);
      chk("R13 sel", int'(rd_sel), 3);
      chk("R13 run", int'(rd_run), 1);

      for (int g = 0; g <= WIN; g++) begin
         wr(1'b1, 1'b1, 9);
         chk("R4 window open", int'(rd_arm), 1);
         chk("R4 sel untouched", int'(rd_sel), 3);
         idle(g);
         if (g == WIN - 1) chk("R6 still open at last cycle", int'(rd_arm), 1);
         if (g == WIN)     chk("R6 closed after window", int'(rd_arm), 0);
         wr(1'b0, 1'b0, 7);
         chk("R5 window closed", int'(rd_arm), 0);
         chk("R5 sel applied", int'(rd_sel), 7);
         if (g < WIN) begin
            chk($sformatf("R5 run cleared gap %0d", g), int'(rd_run), 0);
            ticks(3000, p, l);
            chk("R12 cleared timer silent", p, 0);
            wr(1'b0, 1'b1, 3);
         end else begin
            chk("R6 late write ignored", int'(rd_run), 1);
            wr(1'b0, 1'b1, 3);
         end
      end

      wr(1'b1, 1'b1, 0);
      wr(1'b0, 1'b1, 1);
      chk("R5 run kept with window write", int'(rd_run), 1);
      chk("R5 sel via window", int'(rd_sel), 1);

      // ---------------- level 2 ----------------
      do_reset(1'b1);
      chk("R1 level 2 run", int'(rd_run), 1);
      chk("R1 level 2 sel", int'(rd_sel), 0);
      chk("R1 level 2 arm", int'(rd_arm), 0);
      ticks(1, p, l);
      chk("R7 counting from reset early", p, 0);
      ticks(1, p, l);
      chk("R7 counting from reset expiry", l, 1);
      idle(1);

      wr(1'b0, 1'b1, 4);
      chk("R8 unguarded sel ignored", int'(rd_sel), 0);
      wr(1'b0, 1'b0, 4);
      chk("R7 run stays", int'(rd_run), 1);
      wr(1'b1, 1'b0, 4);
      chk("R13 level 2 bogus arm", int'(rd_arm), 0);
      wr(1'b1, 1'b1, 6);
      chk("R4 level 2 open", int'(rd_arm), 1);
      chk("R4 level 2 sel untouched", int'(rd_sel), 0);
      wr(1'b0, 1'b0, 4);
      chk("R8 sel applied", int'(rd_sel), 4);
      chk("R8 run field ignored", int'(rd_run), 1);
      timeout_run(4);

      wr(1'b1, 1'b1, 0);
      idle(WIN);
      wr(1'b0, 1'b0, 9);
      chk("R6 level 2 late write", int'(rd_sel), 4);

      wr(1'b1, 1'b1, 0);
      idle(2);
      wr(1'b0, 1'b1, 12);
      chk("R8 reserved code stored", int'(rd_sel), 12);
      timeout_run(12);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule